// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a burst-capable synchronous memory. A load cycle captures a full external address. Each advance cycle after it moves only the low beat bits to the next position of a four-beat burst. The upper address bits stay as they were loaded. A static order input selects one of two orders. Linear order counts upward and wraps. Interleaved order XORs the starting beat bits with a running beat count.

The output is formed from two registers: the captured base address and the beat counter. A cycle with the clock enable low is ignored, so a burst can be paused for any number of cycles. If an advance arrives after reset with no load before it, the burst runs from address zero. The memory array and the data path are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and directly after it, `word_addr` is zero.
- R2: A clock-enabled cycle with `advance` low (a load) makes `word_addr` equal to `ext_addr` from the next cycle.
- R3: With `interleave` low (linear order), the low two bits after k clock-enabled advances since the last load equal the loaded low bits plus k, modulo 4.
- R4: With `interleave` high (interleaved order), the low two bits after k advances equal the loaded low bits XOR (k modulo 4).
- R5: Advances never change address bits above bit 1.
- R6: The fourth advance after a load returns `word_addr` to the loaded address and does not carry into the upper bits.
- R7: A cycle with `clk_en` low leaves `word_addr` unchanged, whatever `advance` and `ext_addr` carry in that cycle.
- R8: Advances after reset with no load in between step a burst whose base is zero: 1, 2, 3 and then 0.
- R9: A load in the middle of a burst restarts the beat count, so the next advance yields the second address of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock qualifier; when low the cycle is ignored |
| advance | input | 1 | 1 = step to the next burst beat, 0 = load `ext_addr` |
| interleave | input | 1 | Static order select: 0 = linear, 1 = interleaved |
| ext_addr | input | ADDR_W | External address taken on a load |
| word_addr | output | ADDR_W | Current word address |

## Verification
The bench loads every start address of a 6-bit configuration in both orders and runs six advances from each one. This sweep covers the wrap on the fourth beat. A carry leaking into bit 2, or an XOR that is mixed up with an add, would show there as a wrong upper field or a wrong low pair. Stall cycles are applied in the middle of a burst with a toggling `advance` and a changing `ext_addr`. A design that let either input through during a stall would skip a beat or jump to an unrelated address. Reset is checked by advancing with no prior load, and a load in the middle of a burst is checked for a restart. A beat counter that does not clear would resume at the old position instead of the second address of the new burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORDER_LINEAR      = 1'b0,
      ORDER_INTERLEAVED = 1'b1
   } burst_order_e;

   // Beats per burst for a given beat-field width
   function automatic int unsigned beats_per_burst(input int unsigned beat_w);
      return 32'd1 << beat_w;
   endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              advance,
   output logic [BEAT_W-1:0] beat
);

   localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat <= '0;
      end else if (clk_en) begin
         if (advance) beat <= beat + BEAT_ONE;
         else         beat <= '0;
      end
   end

   // R9: a load clears the beat position
   assert_load_clears_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !advance) |=> (beat == '0));

   // R7: a stalled cycle holds the beat position
   assert_stall_holds_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en) |=> $stable(beat));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int unsigned ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              advance,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] base
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  base <= '0;
      else if (clk_en && !advance) base <= ext_addr;
   end

   // R5: the base never moves on an advance
   assert_base_held_on_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && advance) |=> $stable(base));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              interleave,
   input  logic [BEAT_W-1:0] start_low,
   input  logic [BEAT_W-1:0] beat,
   output logic [BEAT_W-1:0] low_out
);

   logic [BEAT_W-1:0] carry;
   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] xor_low;

   assign carry[0] = 1'b0;

   // Per-bit ripple adder (wrapping) and per-bit XOR map
   for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_bit
      assign xor_low[gi] = start_low[gi] ^ beat[gi];
      assign lin_low[gi] = start_low[gi] ^ beat[gi] ^ carry[gi];
      if (gi < BEAT_W - 1) begin : g_carry
         assign carry[gi+1] = (start_low[gi] & beat[gi]) |
                              (carry[gi] & (start_low[gi] ^ beat[gi]));
      end
   end

   always_comb begin
      if (interleave) low_out = xor_low;
      else            low_out = lin_low;
   end

   // R4: beat zero always maps to the start position, in either order
   always_comb begin
      if (beat == '0) begin
         assert_beat0_is_start_R4: assert (low_out == start_low);
      end
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              advance,
   input  logic              interleave,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] word_addr
);

   localparam int unsigned UPPER_W = ADDR_W - BEAT_W;
   localparam int unsigned NBEATS  = beats_per_burst(BEAT_W);

   if (BEAT_W < 1 || BEAT_W > 4) begin : g_bad_beat
      $error("burst_addr_seq: BEAT_W must be in 1..4");
   end
   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
   end
   if (NBEATS < 2) begin : g_bad_nbeats
      $error("burst_addr_seq: a burst needs at least two beats");
   end

   logic [ADDR_W-1:0] base;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] low;
   burst_order_e      order;

   assign order = burst_order_e'(interleave);

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .advance  (advance),
      .ext_addr (ext_addr),
      .base     (base)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_en  (clk_en),
      .advance (advance),
      .beat    (beat)
   );

   burst_order_map #(.BEAT_W(BEAT_W)) u_map (
      .interleave (order == ORDER_INTERLEAVED),
      .start_low  (base[BEAT_W-1:0]),
      .beat       (beat),
      .low_out    (low)
   );

   assign word_addr = {base[ADDR_W-1:BEAT_W], low};

   // R2: a load presents the external address next cycle
   assert_load_takes_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !advance) |=> (word_addr == $past(ext_addr)));

   // R5: upper bits are untouched by an advance
   assert_upper_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && advance) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

   // R3: linear order steps the low bits by one, wrapping
   assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && advance && !interleave) |=>
         (interleave ||
          word_addr[BEAT_W-1:0] == BEAT_W'($past(word_addr[BEAT_W-1:0]) + BEAT_W'(1))));

   // R7: a stall freezes the address while the order input is static
   assert_stall_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en) |=> ($stable(word_addr) || !$stable(interleave)));

   logic [UPPER_W-1:0] unused_upper_chk;
   assign unused_upper_chk = word_addr[ADDR_W-1:BEAT_W];

   // R1: reset state
   always_comb begin
      if (!rst_n) begin
         assert_reset_zero_R1: assert (word_addr == '0 && unused_upper_chk == '0);
      end
   end

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

   localparam int unsigned AW = 6;
   localparam int unsigned BW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en;
   logic          advance;
   logic          interleave;
   logic [AW-1:0] ext_addr;
   logic [AW-1:0] word_addr;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_burst_addr_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en     (clk_en),
      .advance    (advance),
      .interleave (interleave),
      .ext_addr   (ext_addr),
      .word_addr  (word_addr)
   );

   function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] b,
                                                 input int k, input logic il);
      logic [BW-1:0] s;
      logic [BW-1:0] kk;
      s  = b[BW-1:0];
      kk = BW'(k);
      return {b[AW-1:BW], il ? (s ^ kk) : BW'(s + kk)};
   endfunction

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp,
                        input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset with a pending load on the inputs
      rst_n = 1'b0; clk_en = 1'b1; advance = 1'b0; interleave = 1'b0;
      ext_addr = 6'h2A;
      step(); step();
      check(word_addr, '0, "R1 in reset");
      clk_en = 1'b0;
      rst_n  = 1'b1;
      step();
      check(word_addr, '0, "R1 after reset");

      // R8: advance with no load, both orders
      for (int m = 0; m < 2; m++) begin
         rst_n = 1'b0; step(); rst_n = 1'b1;
         interleave = m[0]; clk_en = 1'b1; advance = 1'b1;
         for (int k = 1; k <= 4; k++) begin
            step();
            check(word_addr, AW'(k % 4), "R8 advance from zero");
         end
      end

      // R2 R3 R4 R5 R6: sweep every start address in both orders
      for (int m = 0; m < 2; m++) begin
         interleave = m[0];
         for (int a = 0; a < (1 << AW); a++) begin
            clk_en = 1'b1; advance = 1'b0; ext_addr = AW'(a);
            step();
            check(word_addr, AW'(a), "R2 load");
            advance = 1'b1; ext_addr = ~AW'(a);
            for (int k = 1; k <= 6; k++) begin
               step();
               if (k == 4)
                  check(word_addr, AW'(a), "R6 wrap to loaded address");
               else if (m == 0)
                  check(word_addr, expect_addr(AW'(a), k, 1'b0), "R3 R5 linear");
               else
                  check(word_addr, expect_addr(AW'(a), k, 1'b1), "R4 R5 interleaved");
            end
         end
      end

      // R7: stall mid-burst with noisy inputs
      for (int m = 0; m < 2; m++) begin
         interleave = m[0];
         clk_en = 1'b1; advance = 1'b0; ext_addr = 6'h35;
         step();
         advance = 1'b1;
         step();
         check(word_addr, expect_addr(6'h35, 1, m[0]), "R7 before stall");
         clk_en = 1'b0;
         for (int s = 0; s < 3; s++) begin
            advance  = s[0];
            ext_addr = AW'(6'h0C + s);
            step();
            check(word_addr, expect_addr(6'h35, 1, m[0]), "R7 stall hold");
         end
         clk_en = 1'b1; advance = 1'b1;
         step();
         check(word_addr, expect_addr(6'h35, 2, m[0]), "R7 resume");
      end

      // R9: load mid-burst restarts the beat
      interleave = 1'b0;
      clk_en = 1'b1; advance = 1'b0; ext_addr = 6'h11;
      step();
      advance = 1'b1; step(); step();
      check(word_addr, 6'h13, "R9 before reload");
      advance = 1'b0; ext_addr = 6'h26;
      step();
      check(word_addr, 6'h26, "R9 reload");
      advance = 1'b1;
      step();
      check(word_addr, 6'h27, "R9 second beat linear");
      interleave = 1'b1;
      advance = 1'b0; ext_addr = 6'h26;
      step();
      advance = 1'b1;
      step();
      check(word_addr, 6'h27, "R9 second beat interleaved");
      step();
      check(word_addr, 6'h24, "R9 third beat interleaved");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule